// File: doc/BRIEF.md
# Strap Latch and Output Mode Controller

This block sits beside the clock synthesizer of a clock generator. While power-on reset is held, a few multi-purpose pins act as configuration inputs. The block follows their levels until reset ends, freezes them two clocks later, and then tells the pads to switch those pins over to driving clocks. The frozen levels supply the default frequency-select code, the management-mode strap and the processor buffer-voltage strap.

A configuration byte from the serial register file then steers operation. One bit decides whether the frequency code comes from the frozen straps or from a 3-bit register field. A 2-bit field sets one of four operating modes: normal, spread-spectrum enable, test, or high impedance. In test mode each output group takes its clock from the test clock, either directly or through a fixed divider. The dividers restart from a low phase each time test mode is entered. For every output group the block produces a 2-bit source select and an output enable.

Top module: `strap_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, and for the first rising edge after it rises, `pin_out_en_o` is 0 and every bit of `grp_oe_o` is 0. After the second rising edge following release, `pin_out_en_o` is 1.
- R2: The strap value held is the level of `strap_i` at the second rising edge after reset release. Later changes on `strap_i` do not alter `strap_mode_o` (`strap_i[3]`), `strap_vsel_o` (`strap_i[4]`) or the strap-derived frequency code.
- R3: When `cfg_i[3]` is 0, `freq_code_o` equals the held `strap_i[2:0]` (bit 2 is the most significant select).
- R4: When `cfg_i[3]` is 1, `freq_code_o` equals `cfg_i[6:4]`.
- R5: In mode `cfg_i[1:0]=00` (normal), every group source is 0 (synthesizer) and every group enable is 1.
- R6: In mode 11 (high impedance), every bit of `grp_oe_o` is 0, including the fixed-frequency group.
- R7: In mode 01 (test), the source codes are 2 (test clock / 2) for groups 0 (processor) and 1 (memory), 3 (test clock / 4) for group 2 (bus), 1 (test clock) for group 3 (reference), and 0 for group 4 (fixed 24/48 MHz). All enables are 1. Group g uses `grp_src_o[2g+1:2g]`.
- R8: `spread_en_o` is 1 only in mode 10 once reset is over. In that mode all sources are 0 and all enables are 1.
- R9: `spread_down_o` equals `cfg_i[2]` and `spread_narrow_o` equals `cfg_i[7]` while `spread_en_o` is 1. Both are 0 otherwise.
- R10: The first rising edge that samples test mode after a non-test cycle leaves `tdiv2_o` and `tdiv4_o` at 0. After k further edges in test mode, `tdiv2_o` is bit 0 of k and `tdiv4_o` is bit 1 of k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, also the test clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| strap_i | input | 5 | Shared-pin levels: [2:0] frequency select, [3] mode, [4] buffer voltage |
| cfg_i | input | 8 | Configuration byte from the register file |
| pin_out_en_o | output | 1 | Shared pins in output function |
| strap_mode_o | output | 1 | Held mode strap |
| strap_vsel_o | output | 1 | Held buffer-voltage strap |
| freq_code_o | output | 3 | Selected frequency code |
| spread_en_o | output | 1 | Spread-spectrum modulation enabled |
| spread_down_o | output | 1 | Down spread (0 = center) |
| spread_narrow_o | output | 1 | Narrow amplitude (0 = wide) |
| grp_src_o | output | 10 | Per-group source select, 2 bits per group |
| grp_oe_o | output | 5 | Per-group output enable |
| tdiv2_o | output | 1 | Test clock divided by 2 |
| tdiv4_o | output | 1 | Test clock divided by 4 |

## Verification
Frequency code, source selects, enables and spread flags are combinational from `cfg_i`. The bench drives `cfg_i` on the falling edge and samples one time unit later. Strap capture and pin handover depend on registers, so they are sampled on the falling edge after the first and second rising edges following release, and the straps are changed only after that. The divider phase is checked on the falling edge after each rising edge, counting from the first edge that sees test mode, both on entry and on re-entry.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int NGRP   = 5;
  localparam int NSTRAP = 5;

  localparam int G_CPU = 0;
  localparam int G_MEM = 1;
  localparam int G_BUS = 2;
  localparam int G_REF = 3;
  localparam int G_FIX = 4;

  typedef enum logic [1:0] {
    SRC_SYN  = 2'd0,
    SRC_TCK  = 2'd1,
    SRC_DIV2 = 2'd2,
    SRC_DIV4 = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    MD_NORM = 2'd0,
    MD_TEST = 2'd1,
    MD_SPRD = 2'd2,
    MD_HIZ  = 2'd3
  } mode_e;

  function automatic src_e test_src(input int g);
    case (g)
      G_CPU, G_MEM: return SRC_DIV2;
      G_BUS:        return SRC_DIV4;
      G_REF:        return SRC_TCK;
      default:      return SRC_SYN;
    endcase
  endfunction
endpackage

// File: rtl/smc_strap_latch.sv
module smc_strap_latch #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] straps_o,
  output logic         done_o
);
  logic [STAGES-1:0] sync_q;
  logic [W-1:0]      straps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  // follows the pins until release completes, then frozen
  always_ff @(posedge clk_i) begin
    if (!sync_q[STAGES-1]) straps_q <= pins_i;
  end

  assign done_o   = sync_q[STAGES-1];
  assign straps_o = straps_q;

  p_done_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  p_strap_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(straps_o));
endmodule

// File: rtl/smc_test_div.sv
module smc_test_div #(
  parameter int DIV_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_i,
  output logic div2_o,
  output logic div4_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             test_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      test_q <= 1'b0;
    end else begin
      test_q <= test_i;
      if (test_i && !test_q) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign div2_o = cnt_q[0];
  assign div4_o = cnt_q[1];

  p_entry_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i && !test_q) |=> (!div2_o && !div4_o));
  p_div2_toggle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i && test_q) |=> (div2_o != $past(div2_o)));
endmodule

// File: rtl/smc_mode_decode.sv
module smc_mode_decode
  import smc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [7:0]        cfg_i,
  output logic              test_o,
  output logic              spread_en_o,
  output logic              spread_down_o,
  output logic              spread_narrow_o,
  output logic [2*NGRP-1:0] grp_src_o,
  output logic [NGRP-1:0]   grp_oe_o
);
  mode_e md;
  assign md = mode_e'(cfg_i[1:0]);

  assign test_o          = active_i && (md == MD_TEST);
  assign spread_en_o     = active_i && (md == MD_SPRD);
  assign spread_down_o   = spread_en_o && cfg_i[2];
  assign spread_narrow_o = spread_en_o && cfg_i[7];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_comb begin
      grp_src_o[2*g +: 2] = test_o ? test_src(g) : SRC_SYN;
      grp_oe_o[g]         = active_i && (md != MD_HIZ);
    end
  end

  p_hiz_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[1:0] == 2'b11) |-> (grp_oe_o == '0));
  p_fix_untouched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_src_o[2*G_FIX +: 2] == SRC_SYN);
endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
  import smc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSTRAP-1:0] strap_i,
  input  logic [7:0]        cfg_i,
  output logic              pin_out_en_o,
  output logic              strap_mode_o,
  output logic              strap_vsel_o,
  output logic [2:0]        freq_code_o,
  output logic              spread_en_o,
  output logic              spread_down_o,
  output logic              spread_narrow_o,
  output logic [2*NGRP-1:0] grp_src_o,
  output logic [NGRP-1:0]   grp_oe_o,
  output logic              tdiv2_o,
  output logic              tdiv4_o
);
  logic [NSTRAP-1:0] straps;
  logic              done;
  logic              test;

  smc_strap_latch #(.W(NSTRAP), .STAGES(SYNC_STAGES)) u_latch (
    .clk_i, .rst_ni, .pins_i(strap_i), .straps_o(straps), .done_o(done)
  );

  smc_mode_decode u_dec (
    .clk_i, .rst_ni, .active_i(done), .cfg_i,
    .test_o(test), .spread_en_o, .spread_down_o, .spread_narrow_o,
    .grp_src_o, .grp_oe_o
  );

  smc_test_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .test_i(test), .div2_o(tdiv2_o), .div4_o(tdiv4_o)
  );

  assign pin_out_en_o = done;
  assign strap_mode_o = straps[3];
  assign strap_vsel_o = straps[4];
  assign freq_code_o  = cfg_i[3] ? cfg_i[6:4] : straps[2:0];

  p_no_drive_in_por_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_out_en_o |-> (grp_oe_o == '0));
  p_reg_freq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_en_o && cfg_i[3] && $stable(cfg_i)) |=> (freq_code_o == $past(cfg_i[6:4])));
endmodule

// File: tb/sim_strap_mode_ctrl.sv
module sim_strap_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] strap = '0;
  logic [7:0] cfg = '0;
  logic       pin_en, s_mode, s_vsel, sp_en, sp_dn, sp_nr, d2, d4;
  logic [2:0] freq;
  logic [9:0] src;
  logic [4:0] oe;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  strap_mode_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .cfg_i(cfg),
    .pin_out_en_o(pin_en), .strap_mode_o(s_mode), .strap_vsel_o(s_vsel),
    .freq_code_o(freq), .spread_en_o(sp_en), .spread_down_o(sp_dn),
    .spread_narrow_o(sp_nr), .grp_src_o(src), .grp_oe_o(oe),
    .tdiv2_o(d2), .tdiv4_o(d4)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic por(input logic [4:0] s);
    @(negedge clk); rst_n = 1'b0; strap = s; cfg = 8'h00;
    @(negedge clk); @(negedge clk);
    chk("R1 pin_en in reset", pin_en, 0);
    chk("R1 oe in reset", oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pin_en edge1", pin_en, 0);
    chk("R1 oe edge1", oe, 0);
    @(negedge clk);
    chk("R1 pin_en edge2", pin_en, 1);
    strap = ~s;
    @(negedge clk); @(negedge clk); #1;
    chk("R2 mode strap", s_mode, s[3]);
    chk("R2 vsel strap", s_vsel, s[4]);
    chk("R3 strap freq", freq, s[2:0]);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 32; s++) por(5'(s));
    por(5'b10110);
    // R4: register frequency field overrides straps
    for (int f = 0; f < 8; f++) begin
      @(negedge clk); cfg = {1'b0, 3'(f), 1'b1, 3'b000}; #1;
      chk("R4 reg freq", freq, f);
      chk("R5 normal oe", oe, 5'h1f);
      chk("R5 normal src", src, 0);
    end
    @(negedge clk); cfg = 8'h00; #1;
    chk("R3 back to straps", freq, 3'b110);
    // sweep modes with every combination of bits 7 and 2
    for (int m = 0; m < 4; m++) begin
      for (int x = 0; x < 4; x++) begin
        logic [7:0] c;
        c = {x[1], 4'b0000, x[0], 2'(m)};
        @(negedge clk); cfg = c; #1;
        chk("R8 spread en", sp_en, m == 2);
        chk("R9 down", sp_dn, (m == 2) && x[0]);
        chk("R9 narrow", sp_nr, (m == 2) && x[1]);
        case (m)
          0: begin chk("R5 src", src, 0); chk("R5 oe", oe, 5'h1f); end
          1: begin chk("R7 src", src, {2'd0, 2'd1, 2'd3, 2'd2, 2'd2}); chk("R7 oe", oe, 5'h1f); end
          2: begin chk("R8 src", src, 0); chk("R8 oe", oe, 5'h1f); end
          default: chk("R6 oe", oe, 0);
        endcase
      end
    end
    // R10: divider phase on entry and re-entry
    for (int rep = 0; rep < 3; rep++) begin
      @(negedge clk); cfg = 8'h00;
      for (int w = 0; w < rep + 2; w++) @(negedge clk);
      cfg = 8'h01;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        chk("R10 div2", d2, k & 1);
        chk("R10 div4", d4, (k >> 1) & 1);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule